// File: doc/BRIEF.md
# CAN Message Buffer Transmit Status Controller

This block holds the 4-bit status field of a single CAN message buffer and moves it between its transmit and receive-ready states. It reacts to CPU writes of the status field and to events from the controller's transmit scheduler: a schedule grant, transmit success, transmit failure, and a delay caused by a higher-priority request. It also reacts to the receipt of a remote frame that matches the buffer.

The block supports three uses. In single-shot transmission, the buffer sends its frame once. In remote-request transmission, the buffer sends a remote frame and then waits to receive data. In automatic answering, the buffer waits for a remote frame, sends its data in reply, and returns to waiting without CPU help.

The status code shows when the buffer is busy on the bus: bit 0 is set only while a scheduled transmission is in flight. Every state change produces one single-cycle event pulse, which the interrupt logic can use.

Top module: `can_txbuf_fsm`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `status_o` is 1000 (idle), `tx_req_o` is 0 and every event output is 0.
- R2: In any non-busy state (status bit 0 clear), a CPU write of 1000, 1100, 1110, 1010 or 0010 loads that code into `status_o` on the next clock and pulses `ev_cpu_o`. A write of any other code leaves the status unchanged and pulses nothing.
- R3: Status 1100 with `sched_grant_i` moves to 1101. Status 1110 with `sched_grant_i` moves to 1111. Both pulse `ev_sched_o`.
- R4: Status 1101 with `tx_done_i` moves to 1000 when `is_remote_i` is 0, or to 0010 when it is 1, and pulses `ev_tx_ok_o`.
- R5: Status 1111 with `tx_done_i` moves to 1010 and pulses `ev_rtr_reply_o`.
- R6: Status 1010 with `rtr_rx_i` moves to 1110 and pulses `ev_rtr_sched_o`.
- R7: In 1101 or 1111, `tx_fail_i` or `preempt_i` without `tx_done_i` returns the status to 1100 or 1110 respectively and pulses `ev_retry_o`. `tx_done_i` takes priority over both.
- R8: In 1101 or 1111, CPU writes have no effect. Without done, fail or preempt, the status holds and no event pulses.
- R9: An accepted CPU write in the same cycle as `sched_grant_i` (in 1100 or 1110) or as `rtr_rx_i` (in 1010) wins. The written code is loaded, and only `ev_cpu_o` pulses.
- R10: `tx_req_o` is 1 exactly while `status_o` is 1100 or 1110.
- R11: The event outputs are registered. An event is high for one cycle, the cycle in which the new status first appears, and at most one event is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU status-write strobe |
| cpu_wdata_i | input | 4 | Status code written by the CPU |
| sched_grant_i | input | 1 | Scheduler picked this buffer for transmission |
| tx_done_i | input | 1 | Transmission completed successfully |
| tx_fail_i | input | 1 | Transmission failed |
| preempt_i | input | 1 | Transmission delayed by a higher-priority request |
| rtr_rx_i | input | 1 | Matching remote frame received |
| is_remote_i | input | 1 | Buffer holds a remote frame |
| status_o | output | 4 | Current status code |
| tx_req_o | output | 1 | Buffer requests transmission |
| ev_cpu_o | output | 1 | Status loaded by a CPU write |
| ev_sched_o | output | 1 | Transmission scheduled |
| ev_tx_ok_o | output | 1 | Single-shot frame sent |
| ev_rtr_reply_o | output | 1 | Answer to a remote frame sent |
| ev_rtr_sched_o | output | 1 | Remote frame received, answer queued |
| ev_retry_o | output | 1 | Failed or delayed transmission re-queued |

## Verification
The contested cycles are a CPU status write landing together with a scheduler grant in a requesting state, or together with a received remote frame in the waiting state. A second contest is a transmit-done arriving in the same cycle as a fail or preempt in a busy state. The bench forces each pairing on purpose: a cancel of 1000 with a grant in 1100, a cancel with a remote frame in 1010, and done with fail in 1101. It then also mixes all inputs at random. A behavioural model that applies the stated priorities is compared with the status, request and event outputs on every clock. The expected winner is the CPU write in the first two cases and the success path in the third.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;
  localparam int unsigned STATUS_W = 4;
  localparam int unsigned EV_W     = 6;

  typedef enum logic [STATUS_W-1:0] {
    ST_IDLE      = 4'b1000,
    ST_ONCE      = 4'b1100,
    ST_BUSY_DATA = 4'b1101,
    ST_ONCE_ANS  = 4'b1110,
    ST_BUSY_ANS  = 4'b1111,
    ST_WAIT_RTR  = 4'b1010,
    ST_RX_READY  = 4'b0010
  } txb_state_e;

  typedef struct packed {
    logic cpu;
    logic sched;
    logic tx_ok;
    logic rtr_reply;
    logic rtr_sched;
    logic retry;
  } txb_ev_t;

  function automatic logic txb_busy(input logic [STATUS_W-1:0] s);
    return (s == ST_BUSY_DATA) || (s == ST_BUSY_ANS);
  endfunction

  function automatic logic txb_writable(input logic [STATUS_W-1:0] c);
    return (c == ST_IDLE) || (c == ST_ONCE) || (c == ST_ONCE_ANS) ||
           (c == ST_WAIT_RTR) || (c == ST_RX_READY);
  endfunction
endpackage

// File: rtl/txb_cpu_decode.sv
module txb_cpu_decode
  import can_txbuf_pkg::*;
(
  input  logic                cpu_wr_i,
  input  logic [STATUS_W-1:0] cpu_wdata_i,
  input  txb_state_e          cur_i,
  output logic                wr_acc_o
);
  // busy states lock out software
  assign wr_acc_o = cpu_wr_i && txb_writable(cpu_wdata_i) && !txb_busy(cur_i);
endmodule

// File: rtl/txb_next_state.sv
module txb_next_state
  import can_txbuf_pkg::*;
(
  input  txb_state_e          cur_i,
  input  logic                wr_acc_i,
  input  logic [STATUS_W-1:0] cpu_wdata_i,
  input  logic                sched_grant_i,
  input  logic                tx_done_i,
  input  logic                tx_fail_i,
  input  logic                preempt_i,
  input  logic                rtr_rx_i,
  input  logic                is_remote_i,
  output txb_state_e          nxt_o,
  output txb_ev_t             ev_o
);
  logic requeue;
  assign requeue = !tx_done_i && (tx_fail_i || preempt_i);

  always_comb begin
    nxt_o = cur_i;
    ev_o  = '0;
    if (wr_acc_i) begin
      nxt_o  = txb_state_e'(cpu_wdata_i);
      ev_o.cpu = 1'b1;
    end else begin
      case (cur_i)
        ST_ONCE: if (sched_grant_i) begin
          nxt_o    = ST_BUSY_DATA;
          ev_o.sched = 1'b1;
        end
        ST_ONCE_ANS: if (sched_grant_i) begin
          nxt_o    = ST_BUSY_ANS;
          ev_o.sched = 1'b1;
        end
        ST_BUSY_DATA: begin
          if (tx_done_i) begin
            nxt_o    = is_remote_i ? ST_RX_READY : ST_IDLE;
            ev_o.tx_ok = 1'b1;
          end else if (requeue) begin
            nxt_o    = ST_ONCE;
            ev_o.retry = 1'b1;
          end
        end
        ST_BUSY_ANS: begin
          if (tx_done_i) begin
            nxt_o        = ST_WAIT_RTR;
            ev_o.rtr_reply = 1'b1;
          end else if (requeue) begin
            nxt_o    = ST_ONCE_ANS;
            ev_o.retry = 1'b1;
          end
        end
        ST_WAIT_RTR: if (rtr_rx_i) begin
          nxt_o        = ST_ONCE_ANS;
          ev_o.rtr_sched = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txb_state_reg.sv
module txb_state_reg
  import can_txbuf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  txb_state_e nxt_i,
  input  txb_ev_t    ev_i,
  output txb_state_e cur_o,
  output txb_ev_t    ev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= ST_IDLE;
      ev_o  <= '0;
    end else begin
      cur_o <= nxt_i;
      ev_o  <= ev_i;
    end
  end
endmodule

// File: rtl/can_txbuf_fsm.sv
module can_txbuf_fsm
  import can_txbuf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_wr_i,
  input  logic [STATUS_W-1:0] cpu_wdata_i,
  input  logic                sched_grant_i,
  input  logic                tx_done_i,
  input  logic                tx_fail_i,
  input  logic                preempt_i,
  input  logic                rtr_rx_i,
  input  logic                is_remote_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                tx_req_o,
  output logic                ev_cpu_o,
  output logic                ev_sched_o,
  output logic                ev_tx_ok_o,
  output logic                ev_rtr_reply_o,
  output logic                ev_rtr_sched_o,
  output logic                ev_retry_o
);
  txb_state_e cur, nxt;
  txb_ev_t    ev_nxt, ev_q;
  logic       wr_acc;

  txb_cpu_decode u_dec (
    .cpu_wr_i    (cpu_wr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cur_i       (cur),
    .wr_acc_o    (wr_acc)
  );

  txb_next_state u_nxt (
    .cur_i         (cur),
    .wr_acc_i      (wr_acc),
    .cpu_wdata_i   (cpu_wdata_i),
    .sched_grant_i (sched_grant_i),
    .tx_done_i     (tx_done_i),
    .tx_fail_i     (tx_fail_i),
    .preempt_i     (preempt_i),
    .rtr_rx_i      (rtr_rx_i),
    .is_remote_i   (is_remote_i),
    .nxt_o         (nxt),
    .ev_o          (ev_nxt)
  );

  txb_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .ev_i   (ev_nxt),
    .cur_o  (cur),
    .ev_o   (ev_q)
  );

  assign status_o       = cur;
  assign tx_req_o       = (cur == ST_ONCE) || (cur == ST_ONCE_ANS);
  assign ev_cpu_o       = ev_q.cpu;
  assign ev_sched_o     = ev_q.sched;
  assign ev_tx_ok_o     = ev_q.tx_ok;
  assign ev_rtr_reply_o = ev_q.rtr_reply;
  assign ev_rtr_sched_o = ev_q.rtr_sched;
  assign ev_retry_o     = ev_q.retry;
endmodule

// File: rtl/txb_chk.sv
module txb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_wr_i,
  input logic [3:0] cpu_wdata_i,
  input logic       sched_grant_i,
  input logic       tx_done_i,
  input logic       tx_fail_i,
  input logic       preempt_i,
  input logic       rtr_rx_i,
  input logic       is_remote_i,
  input logic [3:0] status_o,
  input logic       tx_req_o,
  input logic [5:0] ev_i
);
  AST_SCHED_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1100 && sched_grant_i && !cpu_wr_i) |=> status_o == 4'b1101); // R3
  AST_DATA_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1101 && tx_done_i && !is_remote_i) |=> status_o == 4'b1000); // R4
  AST_REMOTE_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1101 && tx_done_i && is_remote_i) |=> status_o == 4'b0010); // R4
  AST_ANSWER_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1111 && tx_done_i) |=> status_o == 4'b1010); // R5
  AST_RTR_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1010 && rtr_rx_i && !cpu_wr_i) |=> status_o == 4'b1110); // R6
  AST_RETRY_ANS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1111 && !tx_done_i && (tx_fail_i || preempt_i)) |=> status_o == 4'b1110); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !tx_done_i && !tx_fail_i && !preempt_i) |=> $stable(status_o)); // R8
  AST_CANCEL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 4'b1100 && cpu_wr_i && cpu_wdata_i == 4'b1000) |=> status_o == 4'b1000); // R9
  AST_REQ_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (status_o[3:2] == 2'b11 && !status_o[0])); // R10
  AST_EV_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_i)); // R11
endmodule

bind can_txbuf_fsm txb_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_wdata_i   (cpu_wdata_i),
  .sched_grant_i (sched_grant_i),
  .tx_done_i     (tx_done_i),
  .tx_fail_i     (tx_fail_i),
  .preempt_i     (preempt_i),
  .rtr_rx_i      (rtr_rx_i),
  .is_remote_i   (is_remote_i),
  .status_o      (status_o),
  .tx_req_o      (tx_req_o),
  .ev_i          ({ev_cpu_o, ev_sched_o, ev_tx_ok_o, ev_rtr_reply_o, ev_rtr_sched_o, ev_retry_o})
);

// File: tb/tb_can_txbuf_fsm.sv
`timescale 1ns/1ps
module tb_can_txbuf_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 0, grant = 0, done = 0, fail = 0, pre = 0, rrx = 0, rem = 0;
  logic [3:0] wdata = 4'b0;
  logic [3:0] status;
  logic       req, e_cpu, e_sched, e_ok, e_reply, e_rsched, e_retry;
  int         checks = 0, failures = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  can_txbuf_fsm dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(wr), .cpu_wdata_i(wdata),
    .sched_grant_i(grant), .tx_done_i(done), .tx_fail_i(fail), .preempt_i(pre),
    .rtr_rx_i(rrx), .is_remote_i(rem), .status_o(status), .tx_req_o(req),
    .ev_cpu_o(e_cpu), .ev_sched_o(e_sched), .ev_tx_ok_o(e_ok),
    .ev_rtr_reply_o(e_reply), .ev_rtr_sched_o(e_rsched), .ev_retry_o(e_retry)
  );

  // behavioural reference
  int    m_st = 8;
  int    m_ev = 0;  // bit5 cpu .. bit0 retry
  string m_tag = "R1";

  function automatic bit writable(input int c);
    return c == 8 || c == 12 || c == 14 || c == 10 || c == 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 8; m_ev <= 0; m_tag <= "R1";
    end else begin
      int s, e; string t;
      s = m_st; e = 0; t = "R2";
      if (m_st == 13 || m_st == 15) begin
        t = "R8";
        if (done) begin
          if (m_st == 13) begin s = rem ? 2 : 8; e = 8; t = "R4"; end
          else begin s = 10; e = 4; t = "R5"; end
        end else if (fail || pre) begin
          s = (m_st == 13) ? 12 : 14; e = 1; t = "R7";
        end
      end else if (wr && writable(int'(wdata))) begin
        s = int'(wdata); e = 32;
        t = ((grant && (m_st == 12 || m_st == 14)) || (rrx && m_st == 10)) ? "R9" : "R2";
      end else if (grant && m_st == 12) begin s = 13; e = 16; t = "R3"; end
      else if (grant && m_st == 14) begin s = 15; e = 16; t = "R3"; end
      else if (rrx && m_st == 10) begin s = 14; e = 2; t = "R6"; end
      m_st <= s; m_ev <= e; m_tag <= t;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    int ev_act;
    ev_act = {e_cpu, e_sched, e_ok, e_reply, e_rsched, e_retry};
    check(int'(status) == m_st, m_tag, int'(status), m_st);
    check(req == (m_st == 12 || m_st == 14), "R10", int'(req), int'(m_st == 12 || m_st == 14));
    check(ev_act == m_ev, "R11", ev_act, m_ev);
  end

  task automatic step(input bit w, input int d, input bit g, input bit dn,
                      input bit f, input bit p, input bit rx, input bit rm);
    @(negedge clk);
    #1;
    wr = w; wdata = d[3:0]; grant = g; done = dn; fail = f; pre = p; rrx = rx; rem = rm;
  endtask

  task automatic idle_cycle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(status == 4'b1000 && !req &&
          {e_cpu, e_sched, e_ok, e_reply, e_rsched, e_retry} == 0, "R1", int'(status), 8);
    rst_n = 1'b1;
    // R2 R3 R4: data frame single shot
    step(1, 12, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    // R4: remote frame -> rx ready
    step(1, 12, 0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 0, 0, 1);
    // R5 R6 R7: auto answer loop with preempt and fail
    step(1, 14, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    // R9: cancel beats remote frame in wait state
    step(1, 8, 0, 0, 0, 0, 1, 0);
    // R2: illegal code ignored, direct entry to wait state
    step(1, 13, 0, 0, 0, 0, 0, 0);
    step(1, 10, 0, 0, 0, 0, 0, 0);
    // R9: cancel beats grant
    step(1, 12, 0, 0, 0, 0, 0, 0);
    step(1, 8, 1, 0, 0, 0, 0, 0);
    // R8: writes ignored while busy; R7: done beats fail
    step(1, 12, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(1, 8, 0, 0, 0, 0, 0, 0);
    step(1, 14, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0, 0);
    idle_cycle();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 15, int'($urandom_range(0, 15)) | ((r < 8) ? 8 : 0),
           $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end
    idle_cycle();
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule